// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block holds instruction bytes fetched ahead of execution. It sits between a bus port and an instruction decoder, and it stores up to six bytes in a circular store. A fetch controller keeps the next fetch address. When the address is odd it asks the bus for one byte. When the address is even it asks for a two-byte word. It starts a new request only when at least two slots are free. The decoder takes one byte per cycle from the head of the queue and marks whether that byte begins an instruction.

A load strobe, used for a start or a jump, empties the queue, abandons any request still outstanding and restarts fetching at the loaded address. A two-bit status code reports, one clock later, what happened to the queue in each cycle.

The fetch controller has two states. In `FS_IDLE` no request is outstanding. In `FS_WAIT` a request is held on the bus port. The *issue* transition goes from `FS_IDLE` to `FS_WAIT` when two or more slots are free and no load is present. The *retire* transition goes from `FS_WAIT` to `FS_IDLE` on an acknowledge. The *abort* transition goes from `FS_WAIT` to `FS_IDLE` on a load. A load taken in `FS_IDLE` keeps the controller in `FS_IDLE`.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`q_valid` low), the status is 00 and the first request is for address 0.
- R2: A request from an odd address has `bus_pair` low and takes one byte from `bus_rdata[7:0]`. A request from an even address has `bus_pair` high and takes two bytes: `bus_rdata[7:0]` at the address and `bus_rdata[15:8]` at the address plus one.
- R3: A request is started only when two or more of the six slots are free. It is held with a stable address until it is acknowledged or a load arrives.
- R4: Bytes leave the queue in ascending address order from the loaded address, and the queue never holds more than six bytes.
- R5: Each accepted pop frees one slot at once. A push and a pop in the same cycle keep the byte count and the byte order consistent.
- R6: `q_status` in the cycle after an operation reads 00 for no operation, 01 for a pop with `dec_first` high, 11 for a pop with `dec_first` low, and 10 for a load.
- R7: A load empties the queue, drops the outstanding request and restarts fetching at `load_addr`. An acknowledge in the same cycle as the load is ignored.
- R8: A pop while the queue is empty is ignored: the status stays 00 and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Flush the queue and restart fetching |
| load_addr | input | AW | New fetch address |
| bus_req | output | 1 | Fetch request outstanding |
| bus_addr | output | AW | Byte address of the request |
| bus_pair | output | 1 | High when two bytes are requested |
| bus_ack | input | 1 | Request completed, data valid |
| bus_rdata | input | 16 | Returned bytes, lower lane first |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Byte at the head of the queue |
| dec_pop | input | 1 | Decoder takes the head byte |
| dec_first | input | 1 | Popped byte starts an instruction |
| q_status | output | 2 | Queue operation code for the previous cycle |

## Verification
The hardest case to reach is a load that arrives while a request is outstanding, with a stale acknowledge in the same cycle. To reach it, the bench turns off its bus responder so that the request stays pending. It then drives the load and a corrupt acknowledge on the same edge, and checks that the first byte out comes from the new address. Stalling the refill at five bytes from an odd start also needs a decoder that stays idle. That case shows refill resumes only after a single pop frees a second slot. A run with random pop timing and random bus latency then checks the order of the byte stream while pushes and pops coincide.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
    parameter int DEPTH = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    push_n,
    input  logic [15:0]   push_data,
    input  logic          pop,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] count
);
    logic [7:0]    slot [DEPTH];
    logic [PW-1:0] head, tail, tail_nx;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    assign tail_nx   = adv(tail, 2'd1);
    assign head_byte = slot[head];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            tail  <= adv(tail, push_n);
            if (pop) head <= adv(head, 2'd1);
            count <= count + CW'(push_n) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!clr && push_n != 2'd0 && tail == PW'(i))
                slot[i] <= push_data[7:0];
            else if (!clr && push_n == 2'd2 && tail_nx == PW'(i))
                slot[i] <= push_data[15:8];
        end
    end

    // R4: occupancy never exceeds capacity
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R5: a pop only reaches the store when a byte is present
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
    // R7: clear leaves the store empty
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] free_slots,
    input  logic          bus_ack,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_pair,
    output logic [1:0]    push_n
);
    fetch_state_e  state, state_nx;
    logic [AW-1:0] fptr;

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (!load && free_slots >= CW'(2)) state_nx = FS_WAIT;
            FS_WAIT: if (load || bus_ack)               state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            fptr <= '0;
        else if (load)
            fptr <= load_addr;
        else if (state == FS_WAIT && bus_ack)
            fptr <= fptr + (fptr[0] ? AW'(1) : AW'(2));
    end

    always_comb begin
        bus_req  = (state == FS_WAIT);
        bus_addr = fptr;
        bus_pair = !fptr[0];
        push_n   = 2'd0;
        if (bus_req && bus_ack && !load) push_n = bus_pair ? 2'd2 : 2'd1;
    end

    // R3: a request begins only with two or more free slots
    p_issue_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(free_slots) >= CW'(2));
    // R3: an unanswered request is held with a stable address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !load |=> bus_req && $stable(bus_addr));
    // R2: request width follows address parity
    p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_pair == !bus_addr[0]);
    // R7: a load restarts fetching at the loaded address
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bus_addr == $past(load_addr) && !bus_req);
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_pair,
    input  logic          bus_ack,
    input  logic [15:0]   bus_rdata,
    output logic          q_valid,
    output logic [7:0]    q_byte,
    input  logic          dec_pop,
    input  logic          dec_first,
    output logic [1:0]    q_status
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count, free_slots;
    logic [1:0]    push_n;
    logic          pop_ok;
    qstat_e        qs_q;

    assign free_slots = CW'(DEPTH) - count;
    assign q_valid    = (count != '0);
    assign pop_ok     = dec_pop && q_valid && !load;
    assign q_status   = qs_q;

    pfq_fetch_fsm #(.AW(AW), .CW(CW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
        .free_slots(free_slots), .bus_ack(bus_ack), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_pair(bus_pair), .push_n(push_n)
    );

    pfq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(load), .push_n(push_n),
        .push_data(bus_rdata), .pop(pop_ok), .head_byte(q_byte), .count(count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      qs_q <= QS_NONE;
        else if (load)   qs_q <= QS_FLUSH;
        else if (pop_ok) qs_q <= dec_first ? QS_FIRST : QS_NEXT;
        else             qs_q <= QS_NONE;
    end

    // R6: a load is reported as a flush one cycle later
    p_flush_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q_status == 2'b10);
    // R7: the queue is empty after a load
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !q_valid);
    // R8: a pop on an empty queue reports no operation
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pop && !q_valid && !load |=> q_status == 2'b00);
endmodule

// File: tb/tb_instr_prefetch_queue.sv
`timescale 1ns/1ps
module tb_instr_prefetch_queue;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        load = 0;
    logic [19:0] load_addr = '0;
    logic        bus_req, bus_pair, q_valid;
    logic [19:0] bus_addr;
    logic        bus_ack = 0;
    logic [15:0] bus_rdata = '0;
    logic [7:0]  q_byte;
    logic        dec_pop = 0, dec_first = 0;
    logic [1:0]  q_status;

    int nchk = 0, nfail = 0;
    int delivered = 0;
    int lat = 0;
    bit resp_en = 0, bad_pending = 0, done = 0;
    logic [19:0] exp_addr;

    always #2 clk = ~clk;

    instr_prefetch_queue dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_pair(bus_pair),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .q_valid(q_valid),
        .q_byte(q_byte), .dec_pop(dec_pop), .dec_first(dec_first),
        .q_status(q_status)
    );

    function automatic logic [7:0] mb(input logic [19:0] a);
        logic [19:0] t;
        t = a * 20'd13 + (a >> 5) + 20'h3C;
        return t[7:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // bus responder
    initial begin
        int wc;
        wc = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 0;
            else if (bad_pending) begin
                bus_ack = 1; bus_rdata = 16'hDEAD; bad_pending = 0;
            end else if (resp_en && bus_req) begin
                if (wc >= lat) begin
                    chk(bus_pair == !bus_addr[0], "R2 width", bus_pair, !bus_addr[0]);
                    bus_rdata = {mb(bus_addr + 20'd1), mb(bus_addr)};
                    bus_ack = 1;
                    delivered += bus_pair ? 2 : 1;
                    wc = 0;
                end else wc++;
            end else wc = 0;
        end
    end

    task automatic do_load(input logic [19:0] a);
        @(negedge clk); load = 1; load_addr = a;
        @(negedge clk); load = 0;
        chk(q_status == 2'b10, "R6 flush code", q_status, 2);
        chk(!q_valid, "R7 empty after load", q_valid, 0);
        exp_addr = a;
    endtask

    task automatic pop_one(input bit first, input string tag);
        @(negedge clk);
        chk(q_valid, {tag, " valid"}, q_valid, 1);
        chk(q_byte == mb(exp_addr), tag, q_byte, mb(exp_addr));
        exp_addr++;
        dec_pop = 1; dec_first = first;
        @(negedge clk);
        dec_pop = 0;
        chk(q_status == (first ? 2'b01 : 2'b11), "R6 pop code", q_status, first ? 1 : 3);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(q_status == 2'b00, "R1 status", q_status, 0);
        chk(!q_valid, "R1 empty", q_valid, 0);
        @(negedge clk);
        chk(bus_req && bus_addr == 0 && bus_pair, "R1 first request", bus_addr, 0);
    endtask

    task automatic t_fill_odd();
        int d0;
        resp_en = 1; lat = 0;
        do_load(20'h00101);
        d0 = delivered;
        repeat (30) @(negedge clk);
        chk(delivered - d0 == 5, "R3 odd start stalls at five bytes", delivered - d0, 5);
        chk(!bus_req, "R3 no request with one free slot", bus_req, 0);
        pop_one(1, "R4 order");
        repeat (10) @(negedge clk);
        chk(delivered - d0 == 7, "R5 pop frees slot for a word", delivered - d0, 7);
        for (int i = 0; i < 6; i++) pop_one(i == 0, "R4 drain order");
        resp_en = 0;
    endtask

    task automatic t_fill_even();
        int d0;
        resp_en = 1; lat = 2;
        do_load(20'h00200);
        d0 = delivered;
        repeat (40) @(negedge clk);
        chk(delivered - d0 == 6, "R2 even start fills six", delivered - d0, 6);
        for (int i = 0; i < 6; i++) pop_one(i[0], "R4 even order");
        resp_en = 0;
    endtask

    task automatic t_flush_inflight();
        resp_en = 0;
        do_load(20'h00400);
        while (!bus_req) @(negedge clk);
        bad_pending = 1;
        @(negedge clk); load = 1; load_addr = 20'h00533;
        @(negedge clk); load = 0;
        chk(q_status == 2'b10, "R7 flush code", q_status, 2);
        chk(!q_valid, "R7 stale ack dropped", q_valid, 0);
        exp_addr = 20'h00533;
        dec_pop = 1; dec_first = 1;
        @(negedge clk); dec_pop = 0;
        chk(q_status == 2'b00, "R8 empty pop ignored", q_status, 0);
        resp_en = 1; lat = 1;
        while (!q_valid) @(negedge clk);
        pop_one(1, "R7 first byte from new address");
        pop_one(0, "R7 second byte");
        resp_en = 0;
    endtask

    task automatic t_random();
        logic [1:0] exp_qs;
        int k;
        resp_en = 1; lat = 0;
        do_load(20'h00A07);
        exp_qs = 2'b00; k = 0;
        while (k < 300) begin
            @(negedge clk);
            chk(q_status == exp_qs, "R6 random status", q_status, exp_qs);
            lat = $urandom_range(0, 3);
            if (q_valid && $urandom_range(0, 1) == 1) begin
                chk(q_byte == mb(exp_addr), "R5 random order", q_byte, mb(exp_addr));
                exp_addr++; k++;
                dec_pop = 1; dec_first = $urandom_range(0, 1) == 1;
                exp_qs = dec_first ? 2'b01 : 2'b11;
            end else begin
                dec_pop = 0; exp_qs = 2'b00;
            end
        end
        @(negedge clk); dec_pop = 0;
        resp_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill_odd();
        t_fill_even();
        t_flush_inflight();
        t_random();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule